// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block turns three digitized supervisory inputs into a single processor reset. A supply-good flag, produced by an external threshold comparator, holds reset while the supply is out of range. An active-low manual request is accepted only after it has stayed low for a minimum pulse width, and it takes effect after a short fixed delay. An activity line driven by the processor feeds a watchdog. If no edge arrives on that line within the window, a reset pulse is issued.

Every reset is stretched by a timeout period that starts when its cause goes away. One option index picks the stretch period and the watchdog window, independently of each other. A parameter picks the output polarity. All timing is counted on a free-running tick of known period (`TICK_US` microseconds). Periods are converted to tick counts at elaboration by rounding up, with a minimum of one tick.

When the activity line is left static, the block becomes a slow oscillator. Reset is released for one watchdog window and then asserted for one stretch period, and this repeats.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While the synchronized supply-good flag is low, reset is asserted. Reset is released only after the flag has been high for RST ticks in a row. A low level during that wait restarts the wait. With a tick on every clock, release comes RST+2 clocks after the flag rises, the extra 2 clocks being the synchronizer.
- R2: A manual request that stays low for fewer than Q ticks (Q = ceil(MR_QUAL_US/TICK_US)) has no effect. A request held low asserts reset D ticks after qualification (D = ceil(MR_DELAY_US/TICK_US)). With a tick every clock, reset asserts Q+D+3 clocks after the input falls.
- R3: Reset stays asserted while the manual input is held low. It is released RST ticks after the input returns high, which is RST+3 clocks with a tick every clock.
- R4: Every rising or falling edge on the activity line restarts the watchdog window. With a tick every clock and no further edge, reset asserts WD+3 clocks after the last edge.
- R5: When the watchdog window expires, reset is asserted as a pulse lasting exactly RST ticks.
- R6: Option index bits [1:0] select the stretch period from 1.4 ms, 28 ms, 200 ms and 1600 ms (selector values 0 to 3). Index bits [3:2] select the watchdog window from 6.2 ms, 102 ms, 1600 ms and 25600 ms (selector values 0 to 3). Each period becomes ceil(period/TICK_US) ticks.
- R7: With ACTIVE_HIGH=1, `rst_o` is 1 while reset is asserted. With ACTIVE_HIGH=0, `rst_o` is 0 while reset is asserted.
- R8: With the activity line static, the output alternates between released for WD ticks and asserted for RST ticks, so one period is RST+WD ticks.
- R9: The watchdog count is held at zero while reset is asserted. Edges during reset have no lasting effect. The window starts at release, so the next expiry asserts reset exactly WD ticks after release.
- R10: From the asynchronous power-on clear, reset is asserted, and it stays asserted until the first supply-good wait of R1 completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on clear, active low |
| tick_i | input | 1 | Timebase strobe, one clock wide, every TICK_US microseconds |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator (asynchronous) |
| mr_ni | input | 1 | Manual reset request, active low (asynchronous) |
| wd_act_i | input | 1 | Watchdog activity line (asynchronous) |
| rst_o | output | 1 | Processor reset, polarity set by ACTIVE_HIGH |

## Verification
A watchdog expiry and a supply drop can reach the stretch logic as hold causes in the same clock. The bench provokes this by timing the supply drop so that its synchronized low level arrives in exactly the cycle in which the window ends. It then checks three things. Reset must assert at exactly WD ticks after release, with no extra cycle and no missing cycle. Reset must stay asserted while the supply is low. Release must follow RST+2 clocks after the supply returns, which shows that the merged causes leave one clean stretch.

// File: rtl/sup_pkg.sv
package sup_pkg;

   // decoded option index: upper pair picks the window, lower pair the stretch
   typedef struct packed {
      logic [1:0] wd_sel;
      logic [1:0] rst_sel;
   } opt_code_t;

   function automatic int unsigned stretch_us(logic [1:0] sel);
      case (sel)
         2'd0:    return 1400;
         2'd1:    return 28000;
         2'd2:    return 200000;
         default: return 1600000;
      endcase
   endfunction

   function automatic int unsigned window_us(logic [1:0] sel);
      case (sel)
         2'd0:    return 6200;
         2'd1:    return 102000;
         2'd2:    return 1600000;
         default: return 25600000;
      endcase
   endfunction

   // round up to whole ticks, never fewer than one
   function automatic int unsigned us_to_ticks(int unsigned us, int unsigned tick_us);
      int unsigned t;
      t = (us + tick_us - 1) / tick_us;
      return (t == 0) ? 1 : t;
   endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int unsigned         WIDTH     = 1,
   parameter logic [WIDTH-1:0]    RESET_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("sup_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage1;
   logic [WIDTH-1:0] stage2;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage1 <= RESET_VAL;
         stage2 <= RESET_VAL;
      end else begin
         stage1 <= d_i;
         stage2 <= stage1;
      end
   end

   assign q_o = stage2;

endmodule

// File: rtl/sup_mr_qual.sv
module sup_mr_qual #(
   parameter int unsigned QUAL_TICKS  = 5,
   parameter int unsigned DELAY_TICKS = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic req_ni,
   output logic mr_req_o
);

   localparam int unsigned QW = $clog2(QUAL_TICKS + 1);
   localparam int unsigned DW = $clog2(DELAY_TICKS + 1);

   if (QUAL_TICKS < 1 || DELAY_TICKS < 1) begin : g_bad_ticks
      $error("sup_mr_qual: qualification and delay need at least one tick");
   end

   logic [QW-1:0] low_cnt;
   logic [DW-1:0] dly_cnt;
   logic          qualified;

   assign qualified = (low_cnt == QW'(QUAL_TICKS));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         low_cnt <= '0;
         dly_cnt <= '0;
      end else if (req_ni) begin
         low_cnt <= '0;
         dly_cnt <= '0;
      end else if (tick_i) begin
         if (!qualified)
            low_cnt <= low_cnt + 1'b1;
         else if (dly_cnt != DW'(DELAY_TICKS))
            dly_cnt <= dly_cnt + 1'b1;
      end
   end

   assign mr_req_o = (dly_cnt == DW'(DELAY_TICKS));

   AST_MR_RISE_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mr_req_o) |-> $past(!req_ni)); // R2
   AST_MR_DROPS_ON_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ni |=> !mr_req_o); // R3

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
   parameter int unsigned WD_TICKS = 1240
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic act_i,
   input  logic clr_i,
   output logic expire_o
);

   localparam int unsigned WW = $clog2(WD_TICKS + 1);

   if (WD_TICKS < 1) begin : g_bad_window
      $error("sup_wdog: window needs at least one tick");
   end

   logic          act_prev;
   logic          act_edge;
   logic [WW-1:0] win_cnt;
   logic          at_end;

   assign act_edge = act_i ^ act_prev;
   assign at_end   = (win_cnt == WW'(WD_TICKS - 1));
   assign expire_o = !clr_i && tick_i && !act_edge && at_end;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_prev <= 1'b0;
         win_cnt  <= '0;
      end else begin
         act_prev <= act_i;
         if (clr_i || act_edge)
            win_cnt <= '0;
         else if (tick_i)
            win_cnt <= at_end ? '0 : win_cnt + 1'b1;
      end
   end

   AST_EDGE_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_edge |=> (win_cnt == '0)); // R4
   AST_HELD_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (win_cnt == '0)); // R9
   AST_EXPIRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o |=> !expire_o); // R5

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
   parameter int unsigned RST_TICKS = 280
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic hold_i,
   output logic active_o
);

   localparam int unsigned CW = $clog2(RST_TICKS + 1);

   if (RST_TICKS < 1) begin : g_bad_stretch
      $error("sup_stretch: stretch needs at least one tick");
   end

   logic [CW-1:0] cnt;
   logic          active;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (hold_i) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (active && tick_i) begin
         if (cnt == CW'(RST_TICKS - 1)) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign active_o = active;

   AST_HOLD_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> active_o); // R1
   AST_RISE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(active_o) |-> $past(hold_i)); // R5
   AST_RELEASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(active_o) |-> ($past(tick_i) && !$past(hold_i))); // R10

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
   import sup_pkg::*;
#(
   parameter int unsigned TICK_US     = 1,
   parameter int unsigned OPTION      = 0,
   parameter bit          ACTIVE_HIGH = 1'b0,
   parameter int unsigned MR_QUAL_US  = 25,
   parameter int unsigned MR_DELAY_US = 12
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic supply_ok_i,
   input  logic mr_ni,
   input  logic wd_act_i,
   output logic rst_o
);

   localparam opt_code_t   OPT        = opt_code_t'(4'(OPTION));
   localparam int unsigned RST_TICKS  = us_to_ticks(stretch_us(OPT.rst_sel), TICK_US);
   localparam int unsigned WD_TICKS   = us_to_ticks(window_us(OPT.wd_sel), TICK_US);
   localparam int unsigned QUAL_TICKS = us_to_ticks(MR_QUAL_US, TICK_US);
   localparam int unsigned DLY_TICKS  = us_to_ticks(MR_DELAY_US, TICK_US);

   if (OPTION > 15) begin : g_bad_option
      $error("sup_reset_ctrl: OPTION must be 0..15");
   end
   if (TICK_US < 1) begin : g_bad_tick
      $error("sup_reset_ctrl: TICK_US must be at least 1");
   end

   // bit 0 supply-good, bit 1 manual (idle high), bit 2 activity
   logic [2:0] in_sync;
   logic       mr_req;
   logic       wd_expire;
   logic       hold;
   logic       rst_active;

   sup_sync #(.WIDTH(3), .RESET_VAL(3'b010)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({wd_act_i, mr_ni, supply_ok_i}),
      .q_o    (in_sync)
   );

   sup_mr_qual #(.QUAL_TICKS(QUAL_TICKS), .DELAY_TICKS(DLY_TICKS)) u_mr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .req_ni   (in_sync[1]),
      .mr_req_o (mr_req)
   );

   sup_wdog #(.WD_TICKS(WD_TICKS)) u_wd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .act_i    (in_sync[2]),
      .clr_i    (rst_active),
      .expire_o (wd_expire)
   );

   assign hold = !in_sync[0] || mr_req || wd_expire;

   sup_stretch #(.RST_TICKS(RST_TICKS)) u_str (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .hold_i   (hold),
      .active_o (rst_active)
   );

   if (ACTIVE_HIGH) begin : g_pol_high
      assign rst_o = rst_active;
   end else begin : g_pol_low
      assign rst_o = !rst_active;
   end

   AST_SUPPLY_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_sync[0] |=> rst_active); // R1
   AST_EXPIRE_ONLY_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wd_expire |=> $rose(rst_active)); // R8

endmodule

// File: tb/sim_sup_reset_ctrl.sv
module sim_sup_reset_ctrl;

   localparam int TU  = 5;
   localparam int R0  = 280;    // option 0: 1400 us / 5
   localparam int W0  = 1240;   // option 0: 6200 us / 5
   localparam int R1T = 5600;   // option 5: 28000 us / 5
   localparam int W1T = 20400;  // option 5: 102000 us / 5
   localparam int Q   = 5;
   localparam int D   = 3;

   logic clk = 1'b0;
   logic rst_n, tick, sup, mr_n, act;
   logic rst0, rst1;
   int   errs = 0;
   int   checks = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   sup_reset_ctrl #(.TICK_US(TU), .OPTION(0), .ACTIVE_HIGH(1'b0)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .supply_ok_i(sup),
      .mr_ni(mr_n), .wd_act_i(act), .rst_o(rst0));

   sup_reset_ctrl #(.TICK_US(TU), .OPTION(5), .ACTIVE_HIGH(1'b1)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .supply_ok_i(sup),
      .mr_ni(mr_n), .wd_act_i(act), .rst_o(rst1));

   function automatic bit asr(bit which);
      return which ? (rst1 == 1'b1) : (rst0 == 1'b0);
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(bit ok, string tag, int actual, int expected);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   task automatic measure(bit which, bit want, int limit, output int n);
      n = 0;
      do begin
         step();
         n++;
      end while (asr(which) != want && n < limit);
   endtask

   task automatic t_power_on();
      int n;
      rst_n = 1'b0; sup = 1'b0; mr_n = 1'b1; act = 1'b0;
      repeat (3) step();
      chk(rst0 == 1'b0, "R10 u0 asserted in clear", rst0, 0);
      chk(rst1 == 1'b1, "R7 u1 active-high asserted", rst1, 1);
      rst_n = 1'b1;
      repeat (40) step();
      chk(asr(0), "R10 held until supply good", rst0, 0);
      sup = 1'b1;
      measure(0, 0, 5000, n);
      chk(n == R0 + 2, "R1 release delay", n, R0 + 2);
   endtask

   task automatic t_supply_dip();
      int n;
      sup = 1'b0;
      repeat (3) step();
      chk(asr(0), "R1 supply low asserts", rst0, 0);
      sup = 1'b1;
      repeat (100) step();
      chk(asr(0), "R1 still waiting", rst0, 0);
      sup = 1'b0;
      repeat (2) step();
      sup = 1'b1;
      measure(0, 0, 5000, n);
      chk(n == R0 + 2, "R1 dip restarts wait", n, R0 + 2);
   endtask

   task automatic t_mr_short();
      int hits = 0;
      mr_n = 1'b0;
      repeat (Q - 1) step();
      mr_n = 1'b1;
      for (int i = 0; i < 40; i++) begin
         step();
         if (asr(0)) hits++;
      end
      chk(hits == 0, "R2 short manual pulse ignored", hits, 0);
   endtask

   task automatic t_mr_long();
      int n;
      mr_n = 1'b0;
      measure(0, 1, 100, n);
      chk(n == Q + D + 3, "R2 manual assertion latency", n, Q + D + 3);
      repeat (R0 + 100) step();
      chk(asr(0), "R3 held while manual low", rst0, 0);
      mr_n = 1'b1;
      measure(0, 0, 5000, n);
      chk(n == R0 + 3, "R3 manual release delay", n, R0 + 3);
   endtask

   task automatic t_wd_edges();
      int n;
      int hits = 0;
      for (int k = 0; k < 4; k++) begin
         act = ~act;
         for (int i = 0; i < 1000; i++) begin
            step();
            if (asr(0)) hits++;
         end
      end
      chk(hits == 0, "R4 both edge kinds service", hits, 0);
      act = ~act;
      measure(0, 1, 5000, n);
      chk(n == W0 + 3, "R4 expiry after last edge", n, W0 + 3);
      measure(0, 0, 5000, n);
      chk(n == R0, "R5 expiry pulse width", n, R0);
   endtask

   task automatic t_wd_in_reset();
      int n;
      sup = 1'b0;
      repeat (5) step();
      for (int k = 0; k < 3; k++) begin
         act = ~act;
         repeat (50) step();
      end
      sup = 1'b1;
      measure(0, 0, 5000, n);
      chk(n == R0 + 2, "R1 release after dip", n, R0 + 2);
      measure(0, 1, 5000, n);
      chk(n == W0, "R9 window starts at release", n, W0);
   endtask

   task automatic t_osc();
      int hi;
      int lo;
      for (int k = 0; k < 2; k++) begin
         measure(0, 0, 5000, hi);
         measure(0, 1, 5000, lo);
         chk(hi == R0, "R8 asserted span", hi, R0);
         chk(hi + lo == R0 + W0, "R8 oscillation period", hi + lo, R0 + W0);
      end
   endtask

   task automatic t_coincide();
      int n;
      measure(0, 0, 5000, n);
      chk(n == R0, "R5 stretch before coincidence", n, R0);
      repeat (W0 - 3) step();
      sup = 1'b0;
      measure(0, 1, 10, n);
      chk(n == 3, "R1 expiry and supply drop same cycle", n, 3);
      repeat (20) step();
      chk(asr(0), "R1 held during merged cause", rst0, 0);
      sup = 1'b1;
      measure(0, 0, 5000, n);
      chk(n == R0 + 2, "R1 single stretch after merge", n, R0 + 2);
   endtask

   task automatic t_option5();
      int n;
      rst_n = 1'b0; sup = 1'b0;
      repeat (3) step();
      chk(rst1 == 1'b1 && rst0 == 1'b0, "R7 polarities inverse", rst1, 1);
      rst_n = 1'b1;
      repeat (2) step();
      sup = 1'b1;
      measure(1, 0, 8000, n);
      chk(n == R1T + 2, "R6 option 5 stretch", n, R1T + 2);
      chk(rst1 == 1'b0, "R7 active-high released level", rst1, 0);
      measure(1, 1, 25000, n);
      chk(n == W1T, "R6 option 5 window", n, W1T);
      measure(1, 0, 8000, n);
      chk(n == R1T, "R6 option 5 pulse", n, R1T);
   endtask

   initial begin
      tick = 1'b1;
      t_power_on();
      t_supply_dip();
      t_mr_short();
      t_mr_long();
      t_wd_edges();
      t_wd_in_reset();
      t_osc();
      t_coincide();
      t_option5();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule